// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects an on-chip host to an external asynchronous static RAM of 128K words by 24 bits. The host raises a request together with an address, a direction flag and, for writes, the data. It keeps the request raised until a single-cycle acknowledge returns. For reads, the data word is valid on the read-data port from that acknowledge until the next read completes.

On the memory side the controller drives three chip selects of mixed polarity, a write strobe, an output-enable strobe and the address bus. It also drives a data bus split into an output half, an input half and a drive-enable for its own pad drivers. Every strobe width and every setup, hold and float interval is a nanosecond parameter. Each is rounded up to whole cycles of a clock-period parameter, with a floor of one cycle. The memory is kept deselected whenever no transfer is in progress.

At the default 5 ns clock, a read holds output enable low for 3 cycles and then waits 2 float cycles. A write holds the write strobe low for 2 cycles and then spends one hold cycle with the strobe released.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, and whenever no transfer is in progress, the memory is deselected (`mem_ce1_n_o`=1, `mem_ce2_o`=0, `mem_ce3_n_o`=1), `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0 and `ack_o`=0.
- R2: Whenever either strobe is low, the memory is selected by the exact pattern `mem_ce1_n_o`=0, `mem_ce2_o`=1, `mem_ce3_n_o`=0.
- R3: A read (`we_req_i`=0) holds `mem_oe_n_o` low and `mem_we_n_o` high for RD_CYC = ceil(T_AA/clock) consecutive cycles (3 at defaults). The bus is sampled on the edge that ends that interval and presented on `rdata_o`.
- R4: A write (`we_req_i`=1) holds `mem_we_n_o` low for WP_CYC = max(ceil(T_PWE), ceil(T_SD), ceil(T_WC)-1) cycles (2 at defaults). Address and write data stay stable throughout, and the write lands at the addressed word.
- R5: A write is ended by releasing the write strobe and the chip selects on the same edge. The controller then keeps driving the same data for one hold cycle.
- R6: `mem_oe_n_o` stays high for the whole of a write. The controller drives the bus only while `mem_oe_n_o` is high.
- R7: After `mem_oe_n_o` rises, at least HZ_CYC = ceil(T_HZ/clock) cycles (2 at defaults) pass with the bus released before the controller drives it. A read ends with HZ_CYC recovery cycles, and its acknowledge falls in the last of them.
- R8: `ack_o` is high for exactly one cycle per transfer.
- R9: A request is taken only when idle. Changes on `addr_i`, `wdata_i` and `we_req_i` during a transfer do not affect it.
- R10: `rdata_o` keeps the last read word through later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until acknowledge |
| we_req_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data |
| ack_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address bus |
| mem_dq_o | output | 24 | Data bus, driven half |
| mem_dq_i | input | 24 | Data bus, received half |
| mem_dq_oe_o | output | 1 | Enable for the controller's data drivers |
| mem_ce1_n_o | output | 1 | Chip select, active low |
| mem_ce2_o | output | 1 | Chip select, active high |
| mem_ce3_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |

## Verification
Two events can meet in one cycle: the memory releasing the bus after a read, and the controller starting to drive it for the next write. The bench issues a write immediately behind a read. A memory model drives the bus whenever it is selected with output enable low, and the bench flags any cycle where both sides drive. It also measures how many released, output-disabled cycles precede each first drive cycle. The other meeting point is an acknowledge arriving while the request is still raised and its fields are changing. That case is judged by confirming that only the first address and data ever reach the memory pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RREC  = 3'd2,
    ST_WR    = 3'd3,
    ST_WHOLD = 3'd4
  } asram_state_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (cap_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 24,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_AA_PS   = 12000,
  parameter int unsigned T_PWE_PS  = 8000,
  parameter int unsigned T_SD_PS   = 6000,
  parameter int unsigned T_WC_PS   = 12000,
  parameter int unsigned T_HZ_PS   = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_dq_oe_o,
  output logic          mem_ce1_n_o,
  output logic          mem_ce2_o,
  output logic          mem_ce3_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o
);

  localparam int unsigned RD_CYC = max2(cdiv(T_AA_PS, CLK_PS), 1);
  localparam int unsigned WC_M1  = max2(cdiv(T_WC_PS, CLK_PS), 2) - 1;
  localparam int unsigned WP_CYC = max2(max2(cdiv(T_PWE_PS, CLK_PS), cdiv(T_SD_PS, CLK_PS)),
                                        max2(WC_M1, 1));
  localparam int unsigned HZ_CYC = max2(cdiv(T_HZ_PS, CLK_PS), 1);
  localparam int unsigned MAXC   = max2(max2(RD_CYC, WP_CYC), HZ_CYC);
  localparam int unsigned CW     = $clog2(MAXC + 1);
  localparam int unsigned FW     = $clog2(HZ_CYC + 1);

  asram_state_e  state_q, state_d;
  logic          accept, cap, tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  logic sel_d, we_n_d, oe_n_d, dq_oe_d;
  logic sel_q, we_n_q, oe_n_q, dq_oe_q;

  // next-state process
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    cap      = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (we_req_i) begin
          state_d = ST_WR;
          tmr_val = CW'(WP_CYC - 1);
        end else begin
          state_d = ST_RD;
          tmr_val = CW'(RD_CYC - 1);
        end
      end
      ST_RD: if (tmr_done) begin
        cap      = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CW'(HZ_CYC - 1);
        state_d  = ST_RREC;
      end
      ST_RREC:  if (tmr_done) state_d = ST_IDLE;
      ST_WR:    if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // strobe decode of the next state, registered so the pins come from flops
  always_comb begin
    sel_d   = (state_d == ST_RD) || (state_d == ST_WR);
    oe_n_d  = (state_d != ST_RD);
    we_n_d  = (state_d != ST_WR);
    dq_oe_d = (state_d == ST_WR) || (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  asram_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .cap_i    (cap),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dq_i     (mem_dq_i),
    .addr_o   (mem_addr_o),
    .dq_o     (mem_dq_o),
    .rdata_o  (rdata_o)
  );

  assign ack_o       = (state_q == ST_WHOLD) || ((state_q == ST_RREC) && tmr_done);
  assign mem_ce1_n_o = ~sel_q;
  assign mem_ce2_o   = sel_q;
  assign mem_ce3_n_o = ~sel_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_dq_oe_o = dq_oe_q;

  // cycles the bus has been floating with output enable high (saturating)
  logic [FW-1:0] float_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       float_cnt <= FW'(HZ_CYC);
    else if (!oe_n_q)                 float_cnt <= '0;
    else if (!dq_oe_q && (float_cnt != FW'(HZ_CYC))) float_cnt <= float_cnt + 1'b1;
  end

  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mem_ce1_n_o && !mem_ce2_o && mem_ce3_n_o &&
                              mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !ack_o));

  a_r2_select_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o || !mem_oe_n_o) |-> (!mem_ce1_n_o && mem_ce2_o && !mem_ce3_n_o));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_addr_o));

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_dq_o));

  a_r5_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && mem_ce1_n_o && $stable(mem_dq_o)));

  a_r6_drive_only_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> mem_oe_n_o);

  a_r7_float_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe_o) |-> (float_cnt >= FW'(HZ_CYC)));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb_top;

  localparam int AW = 17;
  localparam int DW = 24;
  // expected cycle counts at a 5 ns clock from the ns limits
  localparam int EXP_RD = 3;   // ceil(12/5)
  localparam int EXP_WP = 2;   // max(ceil(8/5), ceil(6/5), ceil(12/5)-1)
  localparam int EXP_HZ = 2;   // ceil(6/5)

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          ack;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_dq_o, m_dq_i;
  logic          m_dq_oe, m_ce1_n, m_ce2, m_ce3_n, m_we_n, m_oe_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_req_i(we_req),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .mem_addr_o(m_addr), .mem_dq_o(m_dq_o), .mem_dq_i(m_dq_i),
    .mem_dq_oe_o(m_dq_oe), .mem_ce1_n_o(m_ce1_n), .mem_ce2_o(m_ce2),
    .mem_ce3_n_o(m_ce3_n), .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n)
  );

  // memory model: 256 words indexed by the low address byte
  logic [DW-1:0] mem [256];
  logic          m_sel;
  logic          m_drive;
  assign m_sel   = !m_ce1_n && m_ce2 && !m_ce3_n;
  assign m_drive = m_sel && !m_oe_n && m_we_n;
  assign m_dq_i  = m_drive ? mem[m_addr[7:0]] : '0;

  // negedge monitor
  int            we_run, oe_run, last_we_run, last_oe_run;
  int            oe_hi, min_gap, bad_sel, contention, ack_long, unstable;
  logic          wr_prev, oe_prev, dq_oe_prev, ack_prev, hold_oe;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;

  initial begin
    we_run = 0; oe_run = 0; last_we_run = 0; last_oe_run = 0;
    oe_hi = 100; min_gap = 100; bad_sel = 0; contention = 0; ack_long = 0; unstable = 0;
    wr_prev = 1'b0; oe_prev = 1'b0; dq_oe_prev = 1'b0; ack_prev = 1'b0; hold_oe = 1'b0;
    w_addr = '0; w_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    if ((!m_we_n || !m_oe_n) && !(m_ce1_n == 1'b0 && m_ce2 == 1'b1 && m_ce3_n == 1'b0))
      bad_sel++;
    if (m_dq_oe && m_drive) contention++;
    if (m_dq_oe && !m_oe_n) contention++;
    if (ack && ack_prev) ack_long++;
    ack_prev = ack;
    if (m_sel && !m_we_n) begin
      if (wr_prev && (m_addr != w_addr || m_dq_o != w_data)) unstable++;
      if (!m_dq_oe) unstable++;
      w_addr = m_addr; w_data = m_dq_o;
      we_run++;
    end else if (wr_prev) begin
      mem[w_addr[7:0]] = w_data;
      last_we_run = we_run; we_run = 0;
      hold_oe = m_dq_oe && (m_dq_o == w_data) && m_ce1_n;
    end
    wr_prev = m_sel && !m_we_n;
    if (!m_oe_n) begin
      oe_run++; oe_hi = 0;
    end else begin
      if (oe_prev) begin last_oe_run = oe_run; oe_run = 0; end
      if (m_dq_oe && !dq_oe_prev && oe_hi < min_gap) min_gap = oe_hi;
      if (!m_dq_oe) oe_hi++;
    end
    oe_prev = !m_oe_n;
    dq_oe_prev = m_dq_oe;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(output bit got);
    got = 1'b0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk); #1;
      if (ack) begin got = 1'b1; break; end
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit got;
    @(negedge clk);
    req = 1'b1; we_req = 1'b1; addr = a; wdata = d;
    wait_ack(got);
    req = 1'b0;
    check(got, "R8 write ack", got, 1);
    check(last_we_run == EXP_WP, "R4 write strobe width", last_we_run, EXP_WP);
    check(w_addr == a, "R4 write address", w_addr, a);
    check(mem[a[7:0]] == d, "R4 written word", mem[a[7:0]], d);
    check(hold_oe, "R5 data held after strobe release", hold_oe, 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    bit got;
    @(negedge clk);
    req = 1'b1; we_req = 1'b0; addr = a; wdata = 24'hDEAD00;
    wait_ack(got);
    req = 1'b0;
    check(got, "R8 read ack", got, 1);
    check(rdata == exp, "R3 read data", rdata, exp);
    check(last_oe_run == EXP_RD, "R3 output-enable width", last_oe_run, EXP_RD);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = 1'b0; we_req = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(m_ce1_n && !m_ce2 && m_ce3_n, "R1 deselected in reset", {m_ce1_n, m_ce2, m_ce3_n}, 3'b101);
    check(m_we_n && m_oe_n && !m_dq_oe && !ack, "R1 strobes in reset",
          {m_we_n, m_oe_n, m_dq_oe, ack}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk); #1;
    check(m_ce1_n && !m_ce2 && m_ce3_n && m_we_n && m_oe_n && !m_dq_oe,
          "R1 idle after reset", {m_ce1_n, m_ce2, m_ce3_n, m_we_n, m_oe_n, m_dq_oe}, 6'b101110);
  endtask

  task automatic t_basic;
    do_write(17'h1_0012, 24'hA5C3E1);
    do_write(17'h0_0034, 24'h000001);
    do_write(17'h1_FFFF, 24'hFFFFFF);
    do_read(17'h1_0012, 24'hA5C3E1);
    do_read(17'h1_FFFF, 24'hFFFFFF);
    do_read(17'h0_0034, 24'h000001);
  endtask

  task automatic t_turnaround;
    // read immediately followed by write: R7 float interval before drive
    do_read(17'h0_0034, 24'h000001);
    do_write(17'h0_0056, 24'h123456);
    check(min_gap >= EXP_HZ, "R7 float cycles before drive", min_gap, EXP_HZ);
    check(contention == 0, "R6 drive only with output enable high", contention, 0);
    do_read(17'h0_0056, 24'h123456);
  endtask

  task automatic t_ignore;
    bit got;
    // R9: fields change while busy; memory must see only the first request
    @(negedge clk);
    req = 1'b1; we_req = 1'b1; addr = 17'h0_0078; wdata = 24'h0F0F0F;
    @(negedge clk);
    addr = 17'h0_009A; wdata = 24'hBADBAD; we_req = 1'b0;
    wait_ack(got);
    req = 1'b0;
    check(got, "R9 ack", got, 1);
    check(w_addr == 17'h0_0078, "R9 address latched", w_addr, 17'h0_0078);
    check(mem[8'h78] == 24'h0F0F0F, "R9 data latched", mem[8'h78], 24'h0F0F0F);
    check(mem[8'h9A] == 24'h0, "R9 other word untouched", mem[8'h9A], 0);
    repeat (2) @(negedge clk); #1;
    check(m_ce1_n && m_we_n && m_oe_n, "R1 idle between transfers",
          {m_ce1_n, m_we_n, m_oe_n}, 3'b111);
  endtask

  task automatic t_rdata_hold;
    do_read(17'h0_0078, 24'h0F0F0F);
    do_write(17'h0_00BC, 24'h777777);
    check(rdata == 24'h0F0F0F, "R10 read data kept over write", rdata, 24'h0F0F0F);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_turnaround();
    t_ignore();
    t_rdata_hold();
    repeat (3) @(negedge clk);
    check(bad_sel == 0, "R2 select pattern", bad_sel, 0);
    check(unstable == 0, "R4 address/data stable in strobe", unstable, 0);
    check(ack_long == 0, "R8 ack one cycle", ack_long, 0);
    check(contention == 0, "R6 no bus contention", contention, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule